// File: doc/BRIEF.md
# Page Programming Buffer with Cycle Timer

This block sits between the serial command decoder of a small non-volatile memory and its storage array. For one array-write command it collects the incoming data bytes into a page-sized holding buffer. The buffer has one valid flag per byte. When the command closes cleanly, the block runs a long, self-timed programming interval and then commits the flagged bytes to an external RAM model, one location per clock.

The decoder marks the start of a command together with its starting address. It then sends one strobe per completed data byte and a closing pulse when chip select rises. It also says whether that rise cut a byte short. The protection unit looks at the current target address, which the block drives, and returns a write-allowed bit for it. The block reports busy for the whole programming interval and raises a one-cycle completion pulse when busy drops. The enclosing logic uses that pulse to clear its write-enable latch.

Top module: `page_prog_buf`

## Requirements
- R1: After reset `busy_o`, `done_o` and `ram_we_o` are 0.
- R2: Bytes are placed at the starting address, then at successive addresses. The low 5 bits (the page offset) wrap from 31 to 0, and the upper address bits never change within a command. `cur_addr_o` shows the address the next byte will take.
- R3: When more than 32 bytes arrive in one command, each offset keeps the last byte sent to it, so the final 32 bytes are what gets committed.
- R4: A partial page commits only the offsets that received a byte. No RAM write is issued for any other location of the page.
- R5: A byte strobed while `wr_allow_i` is 0 is not written to the RAM. The latest strobe at an offset decides whether that offset is written.
- R6: A closing pulse with at least one byte received and `frag_i` = 0 starts programming. `busy_o` then stays 1 for exactly `PROG_CYCLES + 32` cycles, and no RAM write occurs during the first `PROG_CYCLES` of them.
- R7: `done_o` is a single-cycle pulse, raised in the first cycle with `busy_o` = 0 after programming.
- R8: A closing pulse with `frag_i` = 1, or with no byte received, starts nothing. Busy, done and the RAM strobe all stay 0.
- R9: While `busy_o` is 1, command start, byte strobes and closing pulses are ignored. The committed data and the target address are unaffected.
- R10: Every RAM write addresses the page of the command's starting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Pulse: an array-write command begins |
| start_addr_i | input | AW | Starting byte address, taken with `cmd_start_i` |
| byte_stb_i | input | 1 | Pulse: one complete data byte is present |
| byte_i | input | 8 | Data byte, taken with `byte_stb_i` |
| wr_allow_i | input | 1 | Write permission for `cur_addr_o`, taken with `byte_stb_i` |
| cmd_end_i | input | 1 | Pulse: chip select rose, the command ends |
| frag_i | input | 1 | With `cmd_end_i`: the last byte was incomplete |
| cur_addr_o | output | AW | Address the next data byte will occupy |
| busy_o | output | 1 | Programming interval in progress |
| done_o | output | 1 | One-cycle pulse at the end of programming |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | AW | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |

## Verification
Several properties are checked on every cycle: the offset step and the fixed page during loading, and the stable target address while busy. They also cover the single-cycle completion pulse, the absence of RAM strobes in the delay phase, the page bound on every write, and the silence after a fragmented close. Other behaviour only the bench scenarios can show, because it depends on the data flowing end to end. That covers which bytes survive an overflow, which locations a partial or partly protected page leaves alone, and the exact length of the busy window. It also covers that noise sent during programming leaves the committed contents unchanged.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG, ST_COMMIT} pp_state_e;
endpackage

// File: rtl/page_addr_trk.sv
module page_addr_trk #(
  parameter int AW    = 12,
  parameter int OFF_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  localparam int BASE_W = AW - OFF_W;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      base_q <= start_addr_i[AW-1:OFF_W];
      off_q  <= start_addr_i[OFF_W-1:0];
    end else if (adv_i) begin
      off_q  <= off_q + OFF_W'(1);  // natural wrap keeps the page
    end
  end

  assign addr_o = {base_q, off_q};
endmodule

// File: rtl/page_store.sv
module page_store #(
  parameter int PAGE_BYTES = 32,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_ok_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wr_off_i == OFF_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (hit) begin
        data_q[g]  <= wr_data_i;
        valid_q[g] <= wr_ok_i;
      end
    end
  end

  assign rd_data_o  = data_q[rd_off_i];
  assign rd_valid_o = valid_q[rd_off_i];
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CYCLES = 1_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/page_prog_buf.sv
module page_prog_buf
  import page_prog_pkg::*;
#(
  parameter int AW          = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 1_250_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          byte_stb_i,
  input  logic [7:0]    byte_i,
  input  logic          wr_allow_i,
  input  logic          cmd_end_i,
  input  logic          frag_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  pp_state_e        st_q;
  logic             got_q;
  logic [OFF_W-1:0] idx_q;
  logic             accept, take_byte, prog_go, expired;
  logic [7:0]       rd_data;
  logic             rd_valid;

  assign accept    = (st_q == ST_IDLE) || (st_q == ST_LOAD);
  assign take_byte = (st_q == ST_LOAD) && byte_stb_i && !cmd_start_i;
  assign prog_go   = (st_q == ST_LOAD) && !cmd_start_i && cmd_end_i &&
                     (got_q || byte_stb_i) && !frag_i;

  page_addr_trk #(.AW(AW), .OFF_W(OFF_W)) u_trk (
    .clk_i, .rst_ni,
    .load_i      (cmd_start_i && accept),
    .start_addr_i,
    .adv_i       (take_byte),
    .addr_o      (cur_addr_o)
  );

  page_store #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i      (cmd_start_i && accept),
    .wr_i       (take_byte),
    .wr_off_i   (cur_addr_o[OFF_W-1:0]),
    .wr_data_i  (byte_i),
    .wr_ok_i    (wr_allow_i),
    .rd_off_i   (idx_q),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid)
  );

  prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i, .rst_ni,
    .start_i   (prog_go),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      got_q       <= 1'b0;
      idx_q       <= '0;
      done_o      <= 1'b0;
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
    end else begin
      done_o   <= 1'b0;
      ram_we_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_start_i) begin
          st_q  <= ST_LOAD;
          got_q <= 1'b0;
        end
        ST_LOAD: begin
          if (cmd_start_i) got_q <= 1'b0;
          else begin
            if (byte_stb_i) got_q <= 1'b1;
            if (cmd_end_i)  st_q  <= prog_go ? ST_PROG : ST_IDLE;
          end
        end
        ST_PROG: if (expired) begin
          st_q  <= ST_COMMIT;
          idx_q <= '0;
        end
        ST_COMMIT: begin
          ram_we_o    <= rd_valid;
          ram_addr_o  <= {cur_addr_o[AW-1:OFF_W], idx_q};
          ram_wdata_o <= rd_data;
          idx_q       <= idx_q + OFF_W'(1);
          if (idx_q == LAST_OFF) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_PROG) || (st_q == ST_COMMIT);
endmodule

// File: rtl/page_prog_chk.sv
module page_prog_chk
  import page_prog_pkg::*;
#(
  parameter int AW    = 12,
  parameter int OFF_W = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input pp_state_e     st_q,
  input logic          cmd_start_i,
  input logic          byte_stb_i,
  input logic          cmd_end_i,
  input logic          frag_i,
  input logic [AW-1:0] cur_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o
);
  a_r2_offset_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && byte_stb_i && !cmd_start_i) |=>
      cur_addr_o[OFF_W-1:0] == ($past(cur_addr_o[OFF_W-1:0]) + OFF_W'(1)));

  a_r2_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && byte_stb_i && !cmd_start_i) |=>
      $stable(cur_addr_o[AW-1:OFF_W]));

  a_r6_no_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG) |-> !ram_we_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r8_frag_no_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && cmd_end_i && frag_i && !cmd_start_i) |=> !busy_o);

  a_r9_busy_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur_addr_o));

  a_r10_write_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o[AW-1:OFF_W] == cur_addr_o[AW-1:OFF_W]));
endmodule

bind page_prog_buf page_prog_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/page_prog_buf_bench.sv
module page_prog_buf_bench;
  localparam int AW   = 12;
  localparam int PG   = 32;
  localparam int PROG = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, byte_stb = 0, wr_allow = 0, cmd_end = 0, frag = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_d = '0;
  logic [AW-1:0] cur_addr, ram_addr;
  logic busy, done, ram_we;
  logic [7:0] ram_wdata;

  always #2 clk = ~clk;

  page_prog_buf #(.AW(AW), .PAGE_BYTES(PG), .PROG_CYCLES(PROG)) u_page_prog_buf (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .start_addr_i(start_addr),
    .byte_stb_i(byte_stb), .byte_i(byte_d), .wr_allow_i(wr_allow), .cmd_end_i(cmd_end),
    .frag_i(frag), .cur_addr_o(cur_addr), .busy_o(busy), .done_o(done),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata));

  int nchk = 0, nerr = 0;
  bit finished = 0;
  int bcnt, dcnt, first_w;
  logic [7:0] got_m[int];
  logic [7:0] exp_m[int];

  task automatic chk(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (busy) bcnt++;
    if (done) dcnt++;
    if (ram_we) begin
      if (first_w < 0) first_w = bcnt;
      got_m[int'(ram_addr)] = ram_wdata;
    end
  end

  function automatic bit allowed(int a, int prot_lo);
    return a < prot_lo;
  endfunction

  task automatic run_write(int addr, int n, bit fr, int prot_lo, bit noise, string req);
    int off, base, a;
    logic [7:0] b;
    bit go;
    off = addr % PG;
    base = addr - off;
    exp_m.delete();
    got_m.delete();
    bcnt = 0; dcnt = 0; first_w = -1;
    @(negedge clk);
    cmd_start = 1; start_addr = AW'(addr);
    @(negedge clk);
    cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      a = base + off;
      chk(int'(cur_addr) == a, "R2 target address", int'(cur_addr), a);
      b = 8'($urandom);
      byte_d = b; byte_stb = 1; wr_allow = allowed(a, prot_lo);
      if (allowed(a, prot_lo)) exp_m[a] = b;
      else exp_m.delete(a);
      @(negedge clk);
      off = (off + 1) % PG;
    end
    byte_stb = 0; wr_allow = 0;
    cmd_end = 1; frag = fr;
    @(negedge clk);
    cmd_end = 0; frag = 0;
    go = (n > 0) && !fr;
    if (noise) begin
      for (int i = 0; i < 10; i++) begin
        cmd_start = (i == 1); start_addr = AW'(addr + 100);
        byte_stb = (i > 2); byte_d = 8'hA5; wr_allow = 1;
        cmd_end = (i == 8);
        @(negedge clk);
      end
      cmd_start = 0; byte_stb = 0; wr_allow = 0; cmd_end = 0;
    end
    if (go) begin
      for (int i = 0; i < PROG + 100 && dcnt == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(bcnt == PROG + PG, "R6 busy length", bcnt, PROG + PG);
      chk(dcnt == 1, "R7 single done pulse", dcnt, 1);
      if (exp_m.num() > 0)
        chk(first_w > PROG, "R6 no write during delay", first_w, PROG + 1);
      chk(got_m.num() == exp_m.num(), {req, " write count"}, got_m.num(), exp_m.num());
      foreach (exp_m[k])
        chk(got_m.exists(k) && got_m[k] == exp_m[k], {req, " byte value"},
            got_m.exists(k) ? int'(got_m[k]) : -1, int'(exp_m[k]));
      if (noise) chk(busy == 0, "R9 no restart after noise", busy, 0);
    end else begin
      repeat (PROG + PG + 10) @(negedge clk);
      chk(bcnt == 0, "R8 busy stays low", bcnt, 0);
      chk(dcnt == 0, "R8 no done", dcnt, 0);
      chk(got_m.num() == 0, "R8 no RAM write", got_m.num(), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C43));
    bcnt = 0; dcnt = 0; first_w = -1;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(done == 0, "R1 done after reset", done, 0);
    chk(ram_we == 0, "R1 write strobe after reset", ram_we, 0);
    rst_n = 1;
    @(negedge clk);
    run_write(12'h040, 32, 0, 4096, 0, "R2 full page");
    run_write(12'h1BC, 10, 0, 4096, 0, "R2 wrap at offset 31");
    run_write(12'h325, 45, 0, 4096, 0, "R3 overflow keeps last bytes");
    run_write(12'h0A3, 3, 0, 4096, 0, "R4 partial page");
    run_write(12'h7F0, 20, 0, 12'h7F8, 0, "R5 protected bytes");
    run_write(12'h200, 5, 1, 4096, 0, "R8 fragment");
    run_write(12'h300, 0, 0, 4096, 0, "R8 empty");
    run_write(12'h460, 6, 0, 4096, 1, "R9 noise while busy");
    run_write(12'hFFE, 4, 0, 4096, 0, "R10 top page wrap");
    for (int it = 0; it < 6; it++)
      run_write(int'($urandom % 4096), 1 + int'($urandom % 40), 0,
                int'($urandom % 4096), 0, "R3 random command");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule